// File: doc/BRIEF.md
# Two-Level Segment/Page Translation Walker

This block turns a 24-bit virtual address into a 24-bit physical address by walking two tables held in memory. It first fetches a segment descriptor from a table whose base comes from a base-address input. That descriptor gives the base of a 256-entry page table. It then fetches the page descriptor selected by the page field. If either descriptor is marked invalid, the walk stops and reports a fault. The access is not completed, and no descriptor is changed.

On a successful walk the walker keeps the usage flags of the page descriptor up to date. The referenced flag is set on every translation, and the modified flag is set on every write access. The descriptor is written back only if one of these flags actually changes. A second access of the same kind therefore costs exactly two memory reads. The memory port is a plain request/response port. The walker holds its request steady until the memory returns a response-valid pulse for that step.

Top module: `seg_page_walker`

Memory is addressed in 32-bit words. The virtual address has three fields: the segment number in bits 23:20, the page number in bits 19:12, and the byte offset in bits 11:0. In both descriptor kinds, bit 31 is the valid flag. A segment descriptor holds the page table base word address in bits 23:0. A page descriptor holds the referenced flag in bit 30, the modified flag in bit 29, and the physical page number in bits 11:0. Bits 28:12 are kept unchanged.

## Requirements
- R1: While reset is applied and after it is released, with no request, `busy`, `done`, `fault` and `mem_req` are all low.
- R2: The first memory access of a walk is a read (`mem_we` low) at word address `seg_base` + segment number.
- R3: A segment descriptor with bit 31 clear ends the walk with `fault`. No page descriptor read or write follows it.
- R4: The second access is a read at word address (segment descriptor bits 23:0) + page number.
- R5: A page descriptor with bit 31 clear ends the walk with `fault`, and no write is issued.
- R6: When `done` is high, `pa` equals the page descriptor's bits 11:0 followed by the unchanged 12-bit offset.
- R7: The write-back is the page descriptor just read, with bit 30 set and, for a write access, bit 29 set. Every other bit is unchanged, and the write goes to the address the descriptor was read from.
- R8: If bit 30 is already set and either the access is a read or bit 29 is already set, no write-back is issued.
- R9: A memory step holds `mem_req`, `mem_we` and `mem_addr` steady until `mem_rvalid` is seen, and it advances only on that pulse.
- R10: A request is taken only when the walker is idle. `busy` rises on the cycle after acceptance and stays high until the final `done` or `fault`. Requests raised while busy are ignored.
- R11: `done` and `fault` are single-cycle pulses, never both high. The walker is idle on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, taken when idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_va | input | 24 | Virtual address |
| seg_base | input | 24 | Segment table base word address, sampled with the request |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Translation completed, `pa` valid |
| fault | output | 1 | Invalid segment or page descriptor |
| pa | output | 24 | Physical address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 24 | Memory word address |
| mem_wdata | output | 32 | Write data (updated page descriptor) |
| mem_rvalid | input | 1 | Memory response / write acknowledge |
| mem_rdata | input | 32 | Memory read data |

## Verification
The bench targets the cases that decide whether a write-back happens: a clean unreferenced page, a referenced page hit by its first write, and repeated reads and writes that must cost only two reads. A walker that compared the flags wrongly would either skip a needed write-back, leaving the usage flags stale, or write on every access. Invalid segment and invalid page descriptors are both exercised. A design that read the page table after a bad segment would show an extra memory access, and one that wrote after a bad page would corrupt the table. Random memory latency and requests raised while busy expose a walker that samples data before the response pulse, or one that restarts its walk.

// File: rtl/walker_pkg.sv
package walker_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SEG,
    ST_RD_PTE,
    ST_WR_PTE,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  localparam int BIT_VALID = 31;
  localparam int BIT_REF   = 30;
  localparam int BIT_MOD   = 29;
endpackage

// File: rtl/walker_pte_upd.sv
module walker_pte_upd #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] pte_in,
  input  logic          is_write,
  output logic [DW-1:0] pte_out,
  output logic          changed
);
  import walker_pkg::*;

  always_comb begin
    pte_out          = pte_in;
    pte_out[BIT_REF] = 1'b1;
    if (is_write) begin
      pte_out[BIT_MOD] = 1'b1;
    end
    changed = (pte_out != pte_in);
  end
endmodule

// File: rtl/walker_ctrl.sv
module walker_ctrl (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    mem_rvalid,
  input  logic                    seg_ok,
  input  logic                    pte_ok,
  input  logic                    pte_changed,
  output walker_pkg::walk_state_e state,
  output logic                    accept,
  output logic                    busy,
  output logic                    done,
  output logic                    fault,
  output logic                    mem_req,
  output logic                    mem_we
);
  import walker_pkg::*;

  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_RD_SEG;
      ST_RD_SEG: if (mem_rvalid) state_d = seg_ok ? ST_RD_PTE : ST_FAULT;
      ST_RD_PTE: if (mem_rvalid) begin
                   if (!pte_ok)          state_d = ST_FAULT;
                   else if (pte_changed) state_d = ST_WR_PTE;
                   else                  state_d = ST_DONE;
                 end
      ST_WR_PTE: if (mem_rvalid) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      ST_FAULT:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state   = state_q;
  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign mem_req = (state_q == ST_RD_SEG) || (state_q == ST_RD_PTE) || (state_q == ST_WR_PTE);
  assign mem_we  = (state_q == ST_WR_PTE);
  assign busy    = mem_req;
  assign done    = (state_q == ST_DONE);
  assign fault   = (state_q == ST_FAULT);

  AST_END_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> (!done && !fault && state_q == ST_IDLE)); // R11
endmodule

// File: rtl/walker_datapath.sv
module walker_datapath #(
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 12,
  parameter int AW     = 24,
  parameter int DW     = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  walker_pkg::walk_state_e  state,
  input  logic                     accept,
  input  logic                     mem_rvalid,
  input  logic [DW-1:0]            mem_rdata,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_va,
  input  logic                     req_write,
  input  logic [AW-1:0]            seg_base,
  input  logic                     mem_req,
  input  logic                     mem_we,
  output logic                     seg_ok,
  output logic                     pte_ok,
  output logic                     pte_changed,
  output logic [AW-1:0]            mem_addr,
  output logic [DW-1:0]            mem_wdata,
  output logic [PPN_W+OFF_W-1:0]   pa
);
  import walker_pkg::*;

  localparam int VA_W     = SEG_W + PAGE_W + OFF_W;
  localparam int SEG_LSB  = PAGE_W + OFF_W;
  localparam int PAGE_LSB = OFF_W;

  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic [AW-1:0]   base_q;
  logic [AW-1:0]   ptb_q;
  logic [DW-1:0]   pte_q;
  logic [DW-1:0]   pte_new;

  logic ld_ptb, ld_pte;
  assign ld_ptb = (state == ST_RD_SEG) && mem_rvalid;
  assign ld_pte = (state == ST_RD_PTE) && mem_rvalid;

  walker_pte_upd #(.DW(DW)) u_upd (
    .pte_in  (mem_rdata),
    .is_write(wr_q),
    .pte_out (pte_new),
    .changed (pte_changed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      wr_q   <= 1'b0;
      base_q <= '0;
    end else if (accept) begin
      va_q   <= req_va;
      wr_q   <= req_write;
      base_q <= seg_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptb_q <= '0;
    else if (ld_ptb) ptb_q <= mem_rdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pte_q <= '0;
    else if (ld_pte) pte_q <= pte_new;
  end

  logic [SEG_W-1:0]  seg_idx;
  logic [PAGE_W-1:0] page_idx;
  assign seg_idx  = va_q[SEG_LSB +: SEG_W];
  assign page_idx = va_q[PAGE_LSB +: PAGE_W];

  always_comb begin
    if (state == ST_RD_SEG) mem_addr = base_q + AW'(seg_idx);
    else                    mem_addr = ptb_q + AW'(page_idx);
  end

  assign seg_ok    = mem_rdata[BIT_VALID];
  assign pte_ok    = mem_rdata[BIT_VALID];
  assign mem_wdata = pte_q;
  assign pa        = {pte_q[PPN_W-1:0], va_q[OFF_W-1:0]};

  AST_WB_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[BIT_VALID] && mem_wdata[BIT_REF])); // R7
endmodule

// File: rtl/seg_page_walker.sv
module seg_page_walker #(
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 12,
  parameter int AW     = 24,
  parameter int DW     = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [SEG_W+PAGE_W+OFF_W-1:0] req_va,
  input  logic [AW-1:0]                 seg_base,
  output logic                          busy,
  output logic                          done,
  output logic                          fault,
  output logic [PPN_W+OFF_W-1:0]        pa,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [AW-1:0]                 mem_addr,
  output logic [DW-1:0]                 mem_wdata,
  input  logic                          mem_rvalid,
  input  logic [DW-1:0]                 mem_rdata
);
  import walker_pkg::*;

  walk_state_e state;
  logic accept, seg_ok, pte_ok, pte_changed;

  walker_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .mem_rvalid (mem_rvalid),
    .seg_ok     (seg_ok),
    .pte_ok     (pte_ok),
    .pte_changed(pte_changed),
    .state      (state),
    .accept     (accept),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .mem_req    (mem_req),
    .mem_we     (mem_we)
  );

  walker_datapath #(
    .SEG_W(SEG_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
    .PPN_W(PPN_W), .AW(AW), .DW(DW)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .accept     (accept),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .req_va     (req_va),
    .req_write  (req_write),
    .seg_base   (seg_base),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .seg_ok     (seg_ok),
    .pte_ok     (pte_ok),
    .pte_changed(pte_changed),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .pa         (pa)
  );

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!mem_req && !done)); // R5
  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid)); // R10
endmodule

// File: tb/seg_page_walker_bench.sv
module seg_page_walker_bench;
  localparam logic [23:0] STB = 24'h000F00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [23:0] req_va = '0;
  logic [23:0] seg_base = STB;
  logic        busy, done, fault, mem_req, mem_we;
  logic [23:0] pa, mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  seg_page_walker u_seg_page_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_va(req_va), .seg_base(seg_base), .busy(busy), .done(done),
    .fault(fault), .pa(pa), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  // memory model with random latency and an access log
  logic [31:0] mem [0:4095];
  logic [23:0] log_addr [0:1023];
  logic        log_we   [0:1023];
  logic [31:0] log_data [0:1023];
  int log_n = 0;
  int wait_cnt = 0;

  always @(posedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid <= 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[11:0]];
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        log_addr[log_n % 1024] <= mem_addr;
        log_we[log_n % 1024]   <= mem_we;
        log_data[log_n % 1024] <= mem_wdata;
        log_n    <= log_n + 1;
        wait_cnt <= int'($urandom_range(0, 3));
      end else begin
        wait_cnt <= wait_cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // one translation, checked against a model computed from the memory image
  task automatic run_txn(input logic [23:0] va, input bit wr, input bit intrude);
    logic [31:0] se, pte, npte;
    logic [23:0] seg_a, pte_a;
    bit exp_fault, exp_wb, exp_seg_fault;
    int exp_acc, start, n, tmo;
    logic [23:0] exp_pa;
    seg_a = STB + 24'(va[23:20]);
    se = mem[seg_a[11:0]];
    exp_seg_fault = !se[31];
    pte_a = se[23:0] + 24'(va[19:12]);
    pte = mem[pte_a[11:0]];
    npte = pte | 32'h4000_0000 | (wr ? 32'h2000_0000 : 32'h0);
    exp_fault = exp_seg_fault || !pte[31];
    exp_wb = !exp_fault && (npte != pte);
    exp_acc = exp_seg_fault ? 1 : (exp_wb ? 3 : 2);
    exp_pa = {pte[11:0], va[11:0]};

    start = log_n;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr;
    @(negedge clk);
    req_valid = intrude;
    req_va = ~va; req_write = ~wr;
    chk(busy === 1'b1, "R10", "busy after accept", {31'd0, busy}, 32'd1);
    tmo = 0;
    while (!(done || fault) && tmo < 200) begin
      chk(busy === 1'b1, "R10", "busy during walk", {31'd0, busy}, 32'd1);
      @(negedge clk);
      tmo++;
    end
    req_valid = 1'b0;
    chk(tmo < 200, "R9", "walk finished", tmo, 0);
    chk(!(done && fault), "R11", "done and fault together", {30'd0, done, fault}, 0);
    chk(fault === exp_fault, exp_seg_fault ? "R3" : "R5", "fault outcome",
        {31'd0, fault}, {31'd0, exp_fault});
    chk(done === !exp_fault, "R6", "done outcome", {31'd0, done}, {31'd0, !exp_fault});
    if (done && !exp_fault) chk(pa === exp_pa, "R6", "physical address", {8'd0, pa}, {8'd0, exp_pa});
    n = log_n - start;
    chk(n == exp_acc, exp_wb ? "R7" : "R8", "memory access count", n, exp_acc);
    if (n >= 1) begin
      chk(log_addr[start % 1024] === seg_a && !log_we[start % 1024], "R2", "segment read",
          {8'd0, log_addr[start % 1024]}, {8'd0, seg_a});
    end
    if (n >= 2 && !exp_seg_fault) begin
      chk(log_addr[(start+1) % 1024] === pte_a && !log_we[(start+1) % 1024], "R4", "page read",
          {8'd0, log_addr[(start+1) % 1024]}, {8'd0, pte_a});
    end
    if (n >= 3 && exp_wb) begin
      chk(log_we[(start+2) % 1024] && log_addr[(start+2) % 1024] === pte_a, "R7", "write-back addr",
          {8'd0, log_addr[(start+2) % 1024]}, {8'd0, pte_a});
      chk(log_data[(start+2) % 1024] === npte, "R7", "write-back data",
          log_data[(start+2) % 1024], npte);
    end
    if (exp_fault) chk(mem[pte_a[11:0]] === pte, "R5", "table untouched", mem[pte_a[11:0]], pte);
    @(negedge clk);
    chk(!done && !fault && !busy, "R11", "idle after end", {29'd0, done, fault, busy}, 0);
    if (intrude) begin
      repeat (3) @(negedge clk);
      chk(!busy && log_n == start + n, "R10", "request while busy ignored",
          {31'd0, busy}, 0);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4096; i++) begin
      w = $urandom();
      w[31] = ($urandom_range(0, 3) != 0);
      mem[i] = w;
    end
    for (int s = 0; s < 15; s++) begin
      mem[12'hF00 + s] = {($urandom_range(0, 7) != 0), 7'd0, 24'(s * 256)};
    end
    mem[12'hF0F] = 32'h0000_0000;
    mem[12'hF00] = 32'h8000_0000; // segment 0 valid, page table at 0
    mem[12'hF01] = 32'h0000_0100; // segment 1 invalid

    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R1", "in reset",
        {28'd0, busy, done, fault, mem_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R1", "after reset",
        {28'd0, busy, done, fault, mem_req}, 0);

    run_txn(24'h1_23_456, 1'b0, 1'b0);   // R3 invalid segment
    run_txn(24'hF_00_001, 1'b1, 1'b0);   // R3 invalid segment 15
    mem[5] = 32'h8000_0ABC;
    run_txn(24'h0_05_123, 1'b0, 1'b0);   // R7 reference set
    run_txn(24'h0_05_FFF, 1'b0, 1'b0);   // R8 repeat read
    run_txn(24'h0_05_000, 1'b1, 1'b0);   // R7 first write
    run_txn(24'h0_05_777, 1'b1, 1'b0);   // R8 repeat write
    run_txn(24'h0_05_778, 1'b0, 1'b0);   // R8 read of dirty page
    mem[6] = 32'h7FFF_F123;
    run_txn(24'h0_06_010, 1'b1, 1'b0);   // R5 invalid page
    mem[7] = 32'hC000_0321;
    run_txn(24'h0_07_010, 1'b1, 1'b1);   // R10 request while busy
    for (int k = 0; k < 300; k++) begin
      run_txn(24'($urandom()), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    summary();
    $finish;
  end
endmodule